// File: doc/BRIEF.md
# Burst Write Bus Initiator

This block is a bus master that carries out multi-word write bursts on a multiplexed address/data bus of the PCI kind. A local client hands it a start address and a word count through a request handshake. It then streams data words with their byte enables through a valid/ready handshake. The engine runs one address phase and then a sequence of data phases. It tolerates wait states from either side, marks the final word by releasing FRAME, and then lets go of the bus.

Three sideband strobes follow the burst so that a simple local bus can be attached on the target side: an address strobe, a data strobe and a last-of-burst flag. These strobes are only ever active while the engine owns the bus. If no target claims the cycle within a fixed number of data-phase clocks, the engine gives up, releases the bus and raises an error pulse in place of the done pulse.

Top module: `burst_wr_master`

## Requirements
- R1: While idle, and after reset, frame_n and irdy_n are high, ad_oe and cbe_oe are low, as_o, ds_o, blast_o, done and err are low, and req_ready is high.
- R2: In the clock after a request is accepted (req_valid and req_ready high at an edge), the address phase runs for exactly one clock. In that clock frame_n is low, ad_out equals the request address, cbe_out equals the write command 4'b0111, both output enables are high, irdy_n is high and as_o is high.
- R3: In each data phase where a word is held, ad_out carries the word, cbe_out carries its byte enables unchanged, and irdy_n is low. A word moves only at an edge where irdy_n, trdy_n and devsel_n are all low. Words go out in the order they were accepted.
- R4: At an edge where irdy_n is low but trdy_n or devsel_n is high, no word moves. The following clock still shows irdy_n low with the same ad_out and cbe_out.
- R5: When the next local word has not yet arrived, irdy_n stays high during the data phase and frame_n stays low.
- R6: frame_n goes high in the same clock in which irdy_n is low with the final word, and never earlier. This also holds for a one-word burst.
- R7: In the clock after the final transfer, irdy_n and frame_n are high, both output enables are low, and done is high for exactly one clock.
- R8: ds_o is high in every clock whose closing edge moves a word. blast_o is high together with ds_o for the final word only.
- R9: as_o, ds_o and blast_o are low in every clock where the engine does not drive the bus (ad_oe low).
- R10: If devsel_n stays high for DSEL_TO consecutive data-phase clocks, the transfer is abandoned with no word moved. err is then high one clock later (DSEL_TO+1 clocks after the address phase), the bus is released, and done stays low.
- R11: A local word is taken only at an edge where wd_valid and wd_ready are both high. A new request is taken only while idle, and its req_len must be at least 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | DW | Start address of the burst |
| req_len | input | LW | Number of words, at least 1 |
| wd_valid | input | 1 | Local data word offered |
| wd_ready | output | 1 | Engine takes the offered word |
| wd_data | input | DW | Local data word |
| wd_be | input | DW/8 | Byte enables of the local word |
| done | output | 1 | One-clock pulse after a completed burst |
| err | output | 1 | One-clock pulse after a transfer that no target claimed |
| frame_n | output | 1 | Bus frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| ad_out | output | DW | Multiplexed address/data value |
| ad_oe | output | 1 | Drive enable for ad_out |
| cbe_out | output | DW/8 | Command / byte-enable value |
| cbe_oe | output | 1 | Drive enable for cbe_out |
| as_o | output | 1 | Sideband address strobe |
| ds_o | output | 1 | Sideband data strobe |
| blast_o | output | 1 | Sideband last-of-burst |

## Verification
The bench runs several bursts. A gap-free multi-word burst with an immediately ready target checks ordering and the sideband strobes. A one-word burst isolates the case where FRAME falls in the first data phase. A burst with periodic target stalls and a late device select shows that the held word stays put under target waits. Bursts with idle gaps on the local stream separate initiator waits from target waits, and a combined case mixes both. A burst to a target that never answers confirms the timeout, its exact latency, and that no word is reported as moved.

// File: rtl/burst_wr_master.sv
module burst_wr_master #(
  parameter int DW      = 32,
  parameter int LW      = 8,
  parameter int DSEL_TO = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DW-1:0]   req_addr,
  input  logic [LW-1:0]   req_len,
  input  logic            wd_valid,
  output logic            wd_ready,
  input  logic [DW-1:0]   wd_data,
  input  logic [DW/8-1:0] wd_be,
  output logic            done,
  output logic            err,
  output logic            frame_n,
  output logic            irdy_n,
  input  logic            trdy_n,
  input  logic            devsel_n,
  output logic [DW-1:0]   ad_out,
  output logic            ad_oe,
  output logic [DW/8-1:0] cbe_out,
  output logic            cbe_oe,
  output logic            as_o,
  output logic            ds_o,
  output logic            blast_o
);
  localparam int BW = DW / 8;
  localparam int CW = $clog2(DSEL_TO + 1);
  localparam logic [BW-1:0] WR_CMD = BW'(4'b0111);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_REL} state_t;
  state_t st;

  logic [DW-1:0] addr_q, hold_d;
  logic [BW-1:0] hold_be;
  logic          hold_v, seen, abort_q;
  logic [LW-1:0] left, fetch_left;
  logic [CW-1:0] dcnt;

  wire in_addr = (st == S_ADDR);
  wire in_data = (st == S_DATA);
  wire last_w  = (left == LW'(1));
  wire xfer    = in_data && hold_v && !trdy_n && !devsel_n;
  wire to_fire = in_data && !seen && devsel_n && (dcnt == CW'(DSEL_TO - 1));
  wire wd_take = wd_valid && wd_ready;

  assign req_ready = (st == S_IDLE);
  assign wd_ready  = (in_addr || in_data) && (fetch_left != '0) && (!hold_v || xfer) && !to_fire;

  assign frame_n = !(in_addr || (in_data && !(hold_v && last_w)));
  assign irdy_n  = !(in_data && hold_v);
  assign ad_out  = in_addr ? addr_q : hold_d;
  assign cbe_out = in_addr ? WR_CMD : hold_be;
  assign ad_oe   = in_addr || in_data;
  assign cbe_oe  = in_addr || in_data;
  assign as_o    = in_addr;
  assign ds_o    = xfer;
  assign blast_o = xfer && last_w;
  assign done    = (st == S_REL) && !abort_q;
  assign err     = (st == S_REL) && abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      left    <= '0;
      dcnt    <= '0;
      seen    <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          st      <= S_ADDR;
          addr_q  <= req_addr;
          left    <= req_len;
          dcnt    <= '0;
          seen    <= 1'b0;
          abort_q <= 1'b0;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          if (to_fire) begin
            st      <= S_REL;
            abort_q <= 1'b1;
          end else begin
            if (xfer) begin
              left <= left - LW'(1);
              if (last_w) st <= S_REL;
            end
            if (!devsel_n)  seen <= 1'b1;
            else if (!seen) dcnt <= dcnt + CW'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v     <= 1'b0;
      hold_d     <= '0;
      hold_be    <= '0;
      fetch_left <= '0;
    end else begin
      if (req_valid && req_ready) fetch_left <= req_len;
      else if (wd_take)           fetch_left <= fetch_left - LW'(1);
      if (to_fire) hold_v <= 1'b0;
      else if (wd_take) begin
        hold_v  <= 1'b1;
        hold_d  <= wd_data;
        hold_be <= wd_be;
      end else if (xfer) hold_v <= 1'b0;
    end
  end

  p_as_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    as_o |=> !as_o);
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !ds_o && !to_fire) |=> (!irdy_n && $stable(ad_out) && $stable(cbe_out)));
  p_frame_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe && $rose(frame_n)) |-> !irdy_n);
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blast_o |=> (irdy_n && frame_n && !ad_oe && done));
  p_sideband_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ad_oe |-> !(as_o || ds_o || blast_o));
  p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($past(in_data) && $past(devsel_n) && !$past(ds_o)));
  p_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (req_len != '0));
endmodule

// File: tb/burst_wr_master_tb.sv
module burst_wr_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, wd_valid = 1'b0;
  logic [31:0] req_addr = '0, wd_data = '0;
  logic [7:0] req_len = '0;
  logic [3:0] wd_be = '0;
  logic trdy_n = 1'b1, devsel_n = 1'b1;
  logic req_ready, wd_ready, done, err, frame_n, irdy_n, ad_oe, cbe_oe, as_o, ds_o, blast_o;
  logic [31:0] ad_out;
  logic [3:0] cbe_out;

  int checks = 0, errors = 0, cyc = 0, as_cyc = 0;
  bit mon_on = 0, respond = 1;
  int dsel_lat = 0, tgt_stall = 0, dcyc = 0;
  logic [31:0] aq[$];
  logic [36:0] wq[$];

  burst_wr_master #(.DW(32), .LW(8), .DSEL_TO(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .wd_be(wd_be), .done(done), .err(err), .frame_n(frame_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .devsel_n(devsel_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .cbe_out(cbe_out), .cbe_oe(cbe_oe), .as_o(as_o), .ds_o(ds_o),
    .blast_o(blast_o));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wdat(input logic [31:0] a, input int i);
    return {a[15:0] + 16'(i), 16'h5A00 ^ 16'(i * 37)};
  endfunction
  function automatic logic [3:0] wbe(input int i);
    return (i % 4 == 0) ? 4'hF : (4'h1 << (i % 4));
  endfunction

  // target model: reacts only to port values just after each edge
  always @(posedge clk) begin
    #1;
    if ((!frame_n || !irdy_n) && !as_o && ad_oe) dcyc = dcyc + 1;
    else dcyc = 0;
    devsel_n = !(respond && dcyc > dsel_lat);
    trdy_n = !(!devsel_n && (tgt_stall == 0 || (dcyc % tgt_stall) != 0));
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (!ad_oe) chk(!(as_o || ds_o || blast_o), "R9 sideband idle", {as_o, ds_o, blast_o}, 0);
      if (as_o) begin
        as_cyc = cyc;
        if (aq.size() == 0) chk(0, "R2 unexpected address phase", 1, 0);
        else begin
          logic [31:0] ea;
          ea = aq.pop_front();
          chk(ad_out == ea, "R2 address", ad_out, ea);
          chk(cbe_out == 4'b0111 && !frame_n && irdy_n && ad_oe && cbe_oe, "R2 command phase",
              {cbe_out, frame_n, irdy_n, ad_oe, cbe_oe}, {4'b0111, 4'b0111});
        end
      end
      if (ds_o) begin
        if (wq.size() == 0) chk(0, "R10 R3 unexpected transfer", ad_out, 0);
        else begin
          logic [36:0] e;
          e = wq.pop_front();
          chk(ad_out == e[31:0], "R3 data word", ad_out, e[31:0]);
          chk(cbe_out == e[35:32], "R3 byte enables", cbe_out, e[35:32]);
          chk(!irdy_n && !trdy_n && !devsel_n, "R3 handshake lines", {irdy_n, trdy_n, devsel_n}, 0);
          chk(blast_o == e[36], "R8 burst last", blast_o, e[36]);
          chk(frame_n == e[36], "R6 frame on last", frame_n, e[36]);
        end
      end else if (!irdy_n && wq.size() != 0) begin
        chk(ad_out == wq[0][31:0] && cbe_out == wq[0][35:32], "R4 held during wait",
            {cbe_out, ad_out}, {wq[0][35:32], wq[0][31:0]});
        chk(frame_n == wq[0][36], "R6 frame while waiting", frame_n, wq[0][36]);
      end
      if (ad_oe && !as_o && irdy_n) chk(!frame_n, "R5 initiator wait keeps frame", frame_n, 0);
    end
  end

  task automatic run_burst(input logic [31:0] a, input int n, input bit gaps, input bit expect_err);
    bit stop = 0;
    aq.push_back(a);
    if (!expect_err)
      for (int i = 0; i < n; i++) wq.push_back({(i == n - 1), wbe(i), wdat(a, i)});
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_len = 8'(n);
    forever begin @(negedge clk); if (req_ready) break; end
    @(posedge clk); #1;
    req_valid = 0;
    for (int i = 0; i < n && !stop; i++) begin
      if (gaps && (i % 2 == 1)) begin
        wd_valid = 0;
        repeat (2) @(posedge clk);
        #1;
      end
      wd_valid = 1; wd_data = wdat(a, i); wd_be = wbe(i);
      forever begin
        @(negedge clk);
        if (err) begin stop = 1; break; end
        if (wd_ready) break;
      end
      if (!stop) begin @(posedge clk); #1; end
    end
    wd_valid = 0;
    if (!stop) forever begin @(negedge clk); if (done || err) break; end
    chk(err == expect_err, "R10 error flag", err, expect_err);
    chk(done == !expect_err, "R7 done pulse", done, !expect_err);
    chk(irdy_n && frame_n && !ad_oe && !cbe_oe, "R7 bus released", {irdy_n, frame_n, ad_oe, cbe_oe}, 4'b1100);
    if (expect_err) chk(cyc - as_cyc == TO + 1, "R10 timeout latency", cyc - as_cyc, TO + 1);
    @(negedge clk);
    chk(!done && !err && req_ready, "R7 R11 single pulse then idle", {done, err, req_ready}, 3'b001);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    chk(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frame_n && irdy_n && !ad_oe && !cbe_oe && !as_o && !ds_o && !blast_o && !done && !err && req_ready,
        "R1 reset state",
        {frame_n, irdy_n, ad_oe, cbe_oe, as_o, ds_o, blast_o, done, err, req_ready}, 10'b1100000001);
    @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk(frame_n && irdy_n && !ad_oe && req_ready && !wd_ready, "R1 R11 idle after reset",
        {frame_n, irdy_n, ad_oe, req_ready, wd_ready}, 5'b11010);
    mon_on = 1;
    run_burst(32'h1000_0040, 4, 0, 0);          // R3 R8 plain burst
    run_burst(32'h2000_0100, 1, 0, 0);          // R6 one-word burst
    dsel_lat = 2; tgt_stall = 3;
    run_burst(32'h3000_0200, 5, 0, 0);          // R4 target waits
    dsel_lat = 0; tgt_stall = 0;
    run_burst(32'h4000_0300, 6, 1, 0);          // R5 local gaps
    dsel_lat = 1; tgt_stall = 2;
    run_burst(32'h5000_0400, 7, 1, 0);          // R4 R5 mixed
    respond = 0; dsel_lat = 0; tgt_stall = 0;
    run_burst(32'h6000_0500, 3, 0, 1);          // R10 no target
    respond = 1;
    run_burst(32'h7000_0600, 2, 0, 0);          // recovery after timeout
    repeat (3) @(negedge clk);
    chk(aq.size() == 0 && wq.size() == 0, "R3 all expected items seen", aq.size() + wq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule